// File: doc/BRIEF.md
# Self-Refreshing Triplicated Register with Majority Voting

This block holds one data word in three separate copies so that a single-event upset in any one copy never reaches the output. A period strobe marks the nominal capture instant. The block then runs on a faster oversample clock and samples the incoming word into the three copies at staggered ticks. Copy 0 samples at the strobe, copy 1 samples `DLY` ticks later and copy 2 samples `2*DLY` ticks later. A short transient on the input can therefore corrupt at most one copy. At `3*DLY` ticks after the strobe, a bitwise majority of the three copies is loaded into the output register.

Each copy has its own three-input voter. While no capture window is open, the output of that voter is written back into the copy on every tick. A copy that has been upset is therefore repaired on the next tick, and upsets cannot pile up across the many idle ticks between strobes. No single voter feeds more than one copy. While the block is idle, the output register also follows the vote of the copies on every tick. For testing, each copy has an XOR fault-injection input. A disagreement flag rises whenever any copy differs from the vote. The flag is meant for logging only.

Top module: `tmr_refresh_reg`

## Requirements
- R1: Voting is bitwise. An output bit is 1 exactly when at least two of the three copies hold 1 in that bit position. The patterns 011, 101, 110 and 111 give 1, and 000, 001, 010 and 100 give 0.
- R2: Capture is staggered after a strobe that is accepted on edge E0:
  - copy 0 takes `din` on E0;
  - copy 1 takes `din` on E0+`DLY`;
  - copy 2 takes `din` on E0+2*`DLY`;
  - `dout` takes the bitwise vote on E0+3*`DLY`.
- R3: From E0 up to the vote edge, `dout` keeps its value. The vote edge itself is excluded.
- R4: An XOR flip applied to only one copy on any edge does not change `dout`. This holds both inside and outside a capture window.
- R5: When no window is open, every copy is rewritten with the value from its own voter on each edge. A single flipped copy is therefore repaired one edge later, and `mismatch` is high for exactly one cycle.
- R6: `mismatch` is high whenever any copy differs in any bit from the vote of the three copies. This includes the state just after a vote taken from unequal copies.
- R7: A strobe that arrives while a window is open, or on its vote edge, is ignored. It causes no capture and no restart of the window.
- R8: A low `rst_n` sampled on an edge sets all three copies and `dout` to `RST_VAL` and closes any open window. `mismatch` is then 0.
- R9: Single flips of the same bit applied to different copies on consecutive idle edges never change `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversample clock, one edge per tick |
| rst_n | input | 1 | Synchronous reset, active low |
| period_stb | input | 1 | Marks the nominal capture tick of a new word |
| din | input | WIDTH | Word to be stored |
| flip0 | input | WIDTH | XOR fault injection into copy 0 |
| flip1 | input | WIDTH | XOR fault injection into copy 1 |
| flip2 | input | WIDTH | XOR fault injection into copy 2 |
| dout | output | WIDTH | Registered majority of the copies |
| mismatch | output | 1 | Some copy differs from the vote |

## Verification
The following are checked on every cycle:
- the majority rule, on every bit of the output voter;
- that `dout` holds across an open window;
- that a clean idle tick leaves the copies in agreement;
- that a single-copy flip on agreeing copies leaves `dout` unchanged;
- the reset state.

Only the bench scenarios can show the rest:
- that each copy samples `din` on its own staggered tick, which is proved by changing `din` between those ticks;
- that a strobe inside a window is ignored;
- that `mismatch` lasts exactly one cycle;
- that flips spread across copies do not accumulate.

// File: rtl/tmr_pkg.sv
// Shared helpers for the triplicated register.
// Assumes exactly three copies; the voting rule is fixed at two of three.
package tmr_pkg;
    localparam int NCOPY = 3;

    // Two-of-three majority for one bit.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/tmr_voter.sv
// Bitwise two-of-three majority voter, purely combinational.
// Assumes all three inputs have the same width W.
module tmr_voter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    // One majority gate per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = maj3(a[i], b[i], c[i]);
    end
endmodule

// File: rtl/tmr_phase_seq.sv
// Tick sequencer for one capture window.
// An accepted strobe opens the window. Copy k is told to capture k*DLY ticks
// after the strobe, and the vote is taken at 3*DLY ticks, which also closes
// the window. Strobes seen while the window is open are ignored.
// Assumes DLY >= 1.
module tmr_phase_seq #(
    parameter int DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    output logic [2:0] cap,
    output logic       vote_en,
    output logic       busy
);
    localparam int LAST = 3 * DLY;
    localparam int CW   = $clog2(LAST + 1);

    logic [CW-1:0] cnt;

    assign busy    = (cnt != '0);
    assign cap[0]  = stb & ~busy;
    assign vote_en = (cnt == CW'(LAST));

    // Capture strobes for the delayed copies.
    for (genvar k = 1; k < 3; k++) begin : g_cap
        assign cap[k] = (cnt == CW'(k * DLY));
    end

    // Tick counter: starts at the strobe and clears on the vote tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (cap[0])  cnt <= CW'(1);
        else if (vote_en) cnt <= '0;
        else if (busy)    cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/tmr_copy.sv
// One stored copy together with its private refresh voter.
// On its capture tick the copy loads din. While idle it reloads the vote of
// all three copies. Otherwise it holds. The flip input is XORed into the
// next value so that upsets can be injected.
// Assumes the caller supplies all three copies, including this one.
module tmr_copy #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         refresh_en,
    input  logic [W-1:0] din,
    input  logic [W-1:0] flip,
    input  logic [W-1:0] c0,
    input  logic [W-1:0] c1,
    input  logic [W-1:0] c2,
    output logic [W-1:0] q
);
    logic [W-1:0] fix;
    logic [W-1:0] nxt;

    tmr_voter #(.W(W)) u_fix (.a(c0), .b(c1), .c(c2), .y(fix));

    // Choose among capture, refresh and hold.
    always_comb begin
        if (cap)             nxt = din;
        else if (refresh_en) nxt = fix;
        else                 nxt = q;
    end

    // Storage with fault injection applied on top.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= nxt ^ flip;
    end
endmodule

// File: rtl/tmr_refresh_reg.sv
// Triplicated, self-refreshing register with staggered capture.
// Three copies sample din at 0, DLY and 2*DLY ticks after an accepted strobe.
// The output takes their bitwise vote at 3*DLY ticks and follows the vote
// on every idle tick. Each copy has its own refresh voter, and a separate
// fourth voter feeds the output and the disagreement flag.
// Assumes one clk edge per tick and DLY >= 1.
module tmr_refresh_reg
    import tmr_pkg::*;
#(
    parameter int               WIDTH   = 8,
    parameter int               DLY     = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_stb,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] flip0,
    input  logic [WIDTH-1:0] flip1,
    input  logic [WIDTH-1:0] flip2,
    output logic [WIDTH-1:0] dout,
    output logic             mismatch
);
    logic [2:0]                   cap;
    logic                         vote_en;
    logic                         busy;
    logic [NCOPY-1:0][WIDTH-1:0]  cp;
    logic [NCOPY-1:0][WIDTH-1:0]  flips;
    logic [WIDTH-1:0]             vote;

    assign flips = {flip2, flip1, flip0};

    tmr_phase_seq #(.DLY(DLY)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (period_stb),
        .cap     (cap),
        .vote_en (vote_en),
        .busy    (busy)
    );

    // Three copies, each with its own refresh voter.
    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        tmr_copy #(.W(WIDTH), .RST_VAL(RST_VAL)) u_copy (
            .clk        (clk),
            .rst_n      (rst_n),
            .cap        (cap[k]),
            .refresh_en (~busy),
            .din        (din),
            .flip       (flips[k]),
            .c0         (cp[0]),
            .c1         (cp[1]),
            .c2         (cp[2]),
            .q          (cp[k])
        );
    end

    // Output voter, independent of the refresh voters.
    tmr_voter #(.W(WIDTH)) u_out_vote (.a(cp[0]), .b(cp[1]), .c(cp[2]), .y(vote));

    // Output register: loads on the vote tick and on idle ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                dout <= RST_VAL;
        else if (vote_en || !busy) dout <= vote;
    end

    // Disagreement flag for upset logging.
    assign mismatch = |((cp[0] ^ vote) | (cp[1] ^ vote) | (cp[2] ^ vote));
endmodule

// File: rtl/tmr_refresh_chk.sv
// Property checker for tmr_refresh_reg, attached by bind.
// Observes the ports, the window state and the copies.
module tmr_refresh_chk #(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_stb,
    input logic [WIDTH-1:0] flip0,
    input logic [WIDTH-1:0] flip1,
    input logic [WIDTH-1:0] flip2,
    input logic [WIDTH-1:0] dout,
    input logic             mismatch,
    input logic             busy,
    input logic             vote_en,
    input logic [WIDTH-1:0] c0,
    input logic [WIDTH-1:0] c1,
    input logic [WIDTH-1:0] c2,
    input logic [WIDTH-1:0] vote
);
    logic was_rst = 1'b0;

    // Remember whether the last edge applied reset.
    always @(posedge clk) was_rst <= !rst_n;

    // Reset state and the majority rule, sampled mid-cycle.
    always @(negedge clk) begin
        if (was_rst) begin
            AST_RESET_STATE: assert (dout == RST_VAL && !mismatch); // R8
        end
        if (rst_n && !was_rst) begin
            for (int i = 0; i < WIDTH; i++) begin
                AST_MAJORITY_BIT: assert (vote[i] == ($countones({c0[i], c1[i], c2[i]}) >= 2)); // R1
            end
        end
    end

    AST_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !vote_en) |=> $stable(dout)); // R3

    AST_IDLE_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !period_stb && flip0 == '0 && flip1 == '0 && flip2 == '0) |=> !mismatch); // R5

    AST_SINGLE_FLIP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !period_stb && !mismatch && $onehot0({|flip0, |flip1, |flip2})) |=> $stable(dout)); // R4
endmodule

bind tmr_refresh_reg tmr_refresh_chk #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_stb (period_stb),
    .flip0      (flip0),
    .flip1      (flip1),
    .flip2      (flip2),
    .dout       (dout),
    .mismatch   (mismatch),
    .busy       (busy),
    .vote_en    (vote_en),
    .c0         (cp[0]),
    .c1         (cp[1]),
    .c2         (cp[2]),
    .vote       (vote)
);

// File: tb/sim_tmr_refresh_reg.sv
// Bench for tmr_refresh_reg. It walks a table of staggered captures, then
// runs directed tests for reset, injected faults and strobes inside a window.
// The task sequencing assumes DLY == 2.
module sim_tmr_refresh_reg;
    localparam int         W   = 8;
    localparam int         DLY = 2;
    localparam logic [7:0] RV  = 8'hA5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         period_stb = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] flip0 = '0;
    logic [W-1:0] flip1 = '0;
    logic [W-1:0] flip2 = '0;
    logic [W-1:0] dout;
    logic         mismatch;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] prev;

    tmr_refresh_reg #(.WIDTH(W), .DLY(DLY), .RST_VAL(RV)) u0 (
        .clk(clk), .rst_n(rst_n), .period_stb(period_stb), .din(din),
        .flip0(flip0), .flip1(flip1), .flip2(flip2),
        .dout(dout), .mismatch(mismatch)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Each entry: copy-0 word, copy-1 word, copy-2 word, expected vote.
    localparam logic [31:0] VEC [7] = '{
        32'hFF_FF_FF_FF,
        32'h00_00_00_00,
        32'hF0_CC_AA_E8,
        32'h0F_0F_F0_0F,
        32'h3C_C3_3C_3C,
        32'h55_AA_FF_FF,
        32'h12_34_56_16
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One capture window. The strobe is accepted on E0, and the vote lands on E0+6.
    task automatic run_vote(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                            input logic [7:0] exp, input logic [7:0] f0, input logic ign);
        @(negedge clk); din = a; period_stb = 1'b1;        // -> E0
        @(negedge clk); period_stb = 1'b0; din = b; flip0 = f0; // -> E1
        @(negedge clk); flip0 = '0;                          // -> E2, copy 1
        @(negedge clk); din = c; period_stb = ign;           // -> E3
        @(negedge clk); period_stb = 1'b0;                   // -> E4, copy 2
        @(negedge clk); din = ~c;
        chk("R3 dout held inside window", dout, prev);
        @(negedge clk);                                      // -> E6 vote
        @(negedge clk);
        chk("R1 R2 staggered vote", dout, exp);
        chk("R6 mismatch after vote", {7'd0, mismatch},
            {7'd0, (a != b || b != c || f0 != 8'h00)});
        @(negedge clk);
        chk("R5 repaired after window", {7'd0, mismatch}, 8'h00);
        chk("R4 dout after refresh", dout, exp);
        prev = exp;
    endtask

    initial begin
        prev = RV;
        repeat (3) @(negedge clk);
        chk("R8 reset dout", dout, RV);
        chk("R8 reset mismatch", {7'd0, mismatch}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 dout after release", dout, RV);

        for (int i = 0; i < 7; i++)
            run_vote(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 8'h00, 1'b0);

        // R4: copy 0 is flipped after its capture, and the vote still wins.
        run_vote(8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'hFF, 1'b0);
        // R7: a second strobe inside the window is ignored.
        run_vote(8'h11, 8'h11, 8'h11, 8'h11, 8'h00, 1'b1);

        // R5 / R6: one idle flip raises mismatch for exactly one cycle.
        @(negedge clk); flip1 = 8'h01;
        @(negedge clk); flip1 = '0;
        chk("R6 mismatch on idle flip", {7'd0, mismatch}, 8'h01);
        chk("R4 dout unchanged by idle flip", dout, prev);
        @(negedge clk);
        chk("R5 mismatch cleared next cycle", {7'd0, mismatch}, 8'h00);
        chk("R5 dout after repair", dout, prev);

        // R9: the same bit is flipped in different copies on consecutive edges.
        @(negedge clk); flip0 = 8'h80;
        @(negedge clk); flip0 = '0; flip1 = 8'h80;
        chk("R9 dout after flip of copy 0", dout, prev);
        @(negedge clk); flip1 = '0; flip2 = 8'h80;
        chk("R9 dout after flip of copy 1", dout, prev);
        @(negedge clk); flip2 = '0;
        chk("R9 dout after flip of copy 2", dout, prev);
        @(negedge clk);
        chk("R9 dout settled", dout, prev);
        chk("R9 copies agree", {7'd0, mismatch}, 8'h00);

        // R8: reset in the middle of a window.
        @(negedge clk); din = 8'h77; period_stb = 1'b1;
        @(negedge clk); period_stb = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 mid-window reset dout", dout, RV);
        chk("R8 mid-window reset mismatch", {7'd0, mismatch}, 8'h00);
        prev = RV;
        run_vote(8'h5A, 8'h5A, 8'hFF, 8'h5A, 8'h00, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule